// File: doc/BRIEF.md
# Branch Resolution and Next-Address Unit

This block is purely combinational. It chooses the address of the instruction that follows the current one. It takes the current program counter, the two register source operands, an offset that has already been sign-extended, a two-bit instruction class and a three-bit branch condition. From these it produces the next program counter, a flag that reports a control transfer, and the return address that a jump writes to its destination register.

A sequential instruction moves to the next word, four bytes on. A conditional branch compares source 1 with source 2 under one of six conditions: equality, inequality, signed ordering or unsigned ordering. If the comparison holds, the branch moves relative to its own address. A direct jump always moves relative to its own address. A register jump always moves to source 1 plus the offset, with the lowest bit cleared.

The surrounding pipeline does the rest. It decodes the fields, holds the PC register and writes the link value.

Top module: `branch_next_pc`

## Requirements
- R1: With class 2'b00 (sequential), `nextPc` is `pc + 4` and `taken` is 0, whatever the operands and condition are.
- R2: With class 2'b01 (branch), condition 3'b000 is taken when source 1 equals source 2, and condition 3'b001 is taken when they differ.
- R3: Condition 3'b100 is taken when source 1 < source 2 as two's-complement values. Condition 3'b101 is taken when source 1 >= source 2 as two's-complement values.
- R4: Condition 3'b110 is taken when source 1 < source 2 as unsigned values. Condition 3'b111 is taken when source 1 >= source 2 as unsigned values.
- R5: A branch whose condition holds gives `nextPc = pc + imm`, with the offset added to the branch's own address. A branch whose condition fails gives `nextPc = pc + 4` and `taken = 0`.
- R6: With class 2'b10 (direct jump), `taken` is 1 and `nextPc = pc + imm`.
- R7: With class 2'b11 (register jump), `taken` is 1 and `nextPc` is `(src1 + imm)` with bit 0 forced to 0.
- R8: For both jump classes, `linkAddr` is `pc + 4`.
- R9: All address sums wrap modulo 2^32.
- R10: Branch condition codes 3'b010 and 3'b011 are never taken. With these codes the unit behaves as a sequential instruction.

Requirements R1 to R10 are listed in this order for reference only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of the current instruction |
| src1 | input | 32 | First register operand (the base for a register jump) |
| src2 | input | 32 | Second register operand |
| imm | input | 32 | Sign-extended offset |
| instrClass | input | 2 | 00 sequential, 01 branch, 10 direct jump, 11 register jump |
| brCond | input | 3 | Branch condition code |
| nextPc | output | 32 | Address of the next instruction |
| taken | output | 1 | Control transfer occurs |
| linkAddr | output | 32 | Return address for jumps |

## Verification
The bench builds the unit with the default parameters: a 32-bit address width and a 4-byte instruction step. At these values the carries and wraparound at the top of the address space can be reached with operands such as 0xFFFFFFFC. The same values also reach the operand pairs whose signed and unsigned orderings disagree, such as 0x80000000 against 1. Together these cases separate the signed conditions from the unsigned ones and expose a missing bit-0 clear on register jumps.

// File: rtl/branch_next_pc_pkg.sv
package branch_next_pc_pkg;

  typedef enum logic [1:0] {
    CLS_SEQ  = 2'b00,
    CLS_BR   = 2'b01,
    CLS_JAL  = 2'b10,
    CLS_JALR = 2'b11
  } instrClass_e;

  typedef enum logic [2:0] {
    COND_EQ  = 3'b000,
    COND_NE  = 3'b001,
    COND_RS2 = 3'b010,
    COND_RS3 = 3'b011,
    COND_LT  = 3'b100,
    COND_GE  = 3'b101,
    COND_LTU = 3'b110,
    COND_GEU = 3'b111
  } brCond_e;

  // strobes from control to datapath
  typedef struct packed {
    logic redirect;    // select the computed target over the sequential address
    logic useRegBase;  // base is src1 instead of pc
    logic alignClear;  // clear bit 0 of the target
  } pcStrobe_t;

  typedef struct packed {
    logic eq;
    logic ltSigned;
    logic ltUnsigned;
  } cmpFlags_t;

endpackage

// File: rtl/branch_next_pc_datapath.sv
module branch_next_pc_datapath
  import branch_next_pc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src1,
  input  logic [XLEN-1:0] src2,
  input  logic [XLEN-1:0] imm,
  input  pcStrobe_t       strobe,
  output cmpFlags_t       flags,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkAddr
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] baseAddr;
  logic [XLEN-1:0] rawTarget;
  logic [XLEN-1:0] target;
  logic [XLEN:0]   diffWide;

  // comparator: unsigned borrow from a widened subtraction, signed from sign bits
  always_comb begin
    diffWide         = {1'b0, src1} - {1'b0, src2};
    flags.eq         = (src1 == src2);
    flags.ltUnsigned = diffWide[XLEN];
    if (src1[XLEN-1] != src2[XLEN-1]) flags.ltSigned = src1[XLEN-1];
    else                              flags.ltSigned = diffWide[XLEN];
    // equal operands cannot be ordered either way
    assert_eq_excludes_lt_R2: assert (!(flags.eq && (flags.ltSigned || flags.ltUnsigned)))
      else $error("equality and less-than flags both set");
  end

  // address adders, wrapping at the top of the address space
  always_comb begin
    seqPc     = pc + STEP;
    baseAddr  = strobe.useRegBase ? src1 : pc;
    rawTarget = baseAddr + imm;
  end

  genvar gi;
  generate
    for (gi = 0; gi < XLEN; gi++) begin : g_align
      if (gi == 0) begin : g_low
        assign target[gi] = rawTarget[gi] & ~strobe.alignClear;
      end else begin : g_high
        assign target[gi] = rawTarget[gi];
      end
    end
  endgenerate

  always_comb begin
    nextPc   = strobe.redirect ? target : seqPc;
    linkAddr = seqPc;
  end

endmodule

// File: rtl/branch_next_pc_ctrl.sv
module branch_next_pc_ctrl
  import branch_next_pc_pkg::*;
(
  input  instrClass_e cls,
  input  brCond_e     cond,
  input  cmpFlags_t   flags,
  output pcStrobe_t   strobe,
  output logic        taken
);

  logic condTrue;

  always_comb begin
    unique case (cond)
      COND_EQ:  condTrue = flags.eq;
      COND_NE:  condTrue = !flags.eq;
      COND_LT:  condTrue = flags.ltSigned;
      COND_GE:  condTrue = !flags.ltSigned;
      COND_LTU: condTrue = flags.ltUnsigned;
      COND_GEU: condTrue = !flags.ltUnsigned;
      default:  condTrue = 1'b0;
    endcase
  end

  always_comb begin
    strobe = '0;
    taken  = 1'b0;
    unique case (cls)
      CLS_SEQ: taken = 1'b0;
      CLS_BR: begin
        taken           = condTrue;
        strobe.redirect = condTrue;
      end
      CLS_JAL: begin
        taken           = 1'b1;
        strobe.redirect = 1'b1;
      end
      CLS_JALR: begin
        taken             = 1'b1;
        strobe.redirect   = 1'b1;
        strobe.useRegBase = 1'b1;
        strobe.alignClear = 1'b1;
      end
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/branch_next_pc.sv
module branch_next_pc
  import branch_next_pc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src1,
  input  logic [XLEN-1:0] src2,
  input  logic [XLEN-1:0] imm,
  input  logic [1:0]      instrClass,
  input  logic [2:0]      brCond,
  output logic [XLEN-1:0] nextPc,
  output logic            taken,
  output logic [XLEN-1:0] linkAddr
);

  pcStrobe_t   strobe;
  cmpFlags_t   flags;
  instrClass_e clsE;
  brCond_e     condE;

  assign clsE  = instrClass_e'(instrClass);
  assign condE = brCond_e'(brCond);

  branch_next_pc_ctrl u_ctrl (
    .cls    (clsE),
    .cond   (condE),
    .flags  (flags),
    .strobe (strobe),
    .taken  (taken)
  );

  branch_next_pc_datapath #(
    .XLEN        (XLEN),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_dp (
    .pc       (pc),
    .src1     (src1),
    .src2     (src2),
    .imm      (imm),
    .strobe   (strobe),
    .flags    (flags),
    .nextPc   (nextPc),
    .linkAddr (linkAddr)
  );

  // cross-checks between the control decision and the datapath result
  always_comb begin
    assert_seq_no_take_R1: assert (!(instrClass == 2'b00 && taken))
      else $error("sequential class reported a transfer");
    assert_fallthrough_R5: assert (taken || nextPc == linkAddr)
      else $error("no transfer but next address is not the sequential one");
    assert_jump_taken_R6: assert (!(instrClass[1] && !taken))
      else $error("jump class without transfer");
    assert_jalr_align_R7: assert (!(instrClass == 2'b11 && nextPc[0]))
      else $error("register jump target has bit 0 set");
  end

endmodule

// File: tb/branch_next_pc_bench.sv
module branch_next_pc_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] pc, src1, src2, imm;
  logic [1:0]  instrClass;
  logic [2:0]  brCond;
  logic [31:0] nextPc, linkAddr;
  logic        taken;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_next_pc u_branch_next_pc (
    .pc(pc), .src1(src1), .src2(src2), .imm(imm),
    .instrClass(instrClass), .brCond(brCond),
    .nextPc(nextPc), .taken(taken), .linkAddr(linkAddr)
  );

  // independent model of the condition table
  function automatic bit modelCond(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) <  $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a <  b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic [31:0] p, a, b, i, input logic [1:0] c, input logic [2:0] cd);
    @(posedge clk);
    pc = p; src1 = a; src2 = b; imm = i; instrClass = c; brCond = cd;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic runBranch(input string req, input logic [2:0] cd, input logic [31:0] a, b);
    bit t;
    drive(32'h0000_1000, a, b, 32'hFFFF_FFF0, 2'b01, cd);
    t = modelCond(cd, a, b);
    chk(req, {31'd0, taken}, {31'd0, t});
    chk(req, nextPc, t ? 32'h0000_0FF0 : 32'h0000_1004);
  endtask

  task automatic testSequential(); // R1
    drive(32'h0000_0000, 32'h5, 32'h5, 32'h100, 2'b00, 3'b000);
    chk("R1 next", nextPc, 32'h4);
    chk("R1 taken", {31'd0, taken}, 32'd0);
    drive(32'h0040_0010, 32'h1, 32'h2, 32'h80, 2'b00, 3'b110);
    chk("R1 next2", nextPc, 32'h0040_0014);
  endtask

  task automatic testEquality(); // R2
    runBranch("R2 beq hit", 3'b000, 32'h1234, 32'h1234);
    runBranch("R2 beq miss", 3'b000, 32'h1234, 32'h1235);
    runBranch("R2 bne hit", 3'b001, 32'h0, 32'h8000_0000);
    runBranch("R2 bne miss", 3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic testSigned(); // R3
    runBranch("R3 blt neg<pos", 3'b100, 32'h8000_0000, 32'h1);
    runBranch("R3 blt pos>neg", 3'b100, 32'h1, 32'hFFFF_FFFF);
    runBranch("R3 bge eq", 3'b101, 32'h7, 32'h7);
    runBranch("R3 bge neg", 3'b101, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
  endtask

  task automatic testUnsigned(); // R4
    runBranch("R4 bltu big", 3'b110, 32'h8000_0000, 32'h1);
    runBranch("R4 bltu small", 3'b110, 32'h1, 32'hFFFF_FFFF);
    runBranch("R4 bgeu eq", 3'b111, 32'h0, 32'h0);
    runBranch("R4 bgeu less", 3'b111, 32'h3, 32'h4);
  endtask

  task automatic testBranchBase(); // R5: offset from branch address, not pc+4
    drive(32'h0000_2000, 32'h9, 32'h9, 32'h0000_0008, 2'b01, 3'b000);
    chk("R5 taken target", nextPc, 32'h0000_2008);
    drive(32'h0000_2000, 32'h9, 32'h8, 32'h0000_0008, 2'b01, 3'b000);
    chk("R5 fallthrough", nextPc, 32'h0000_2004);
    chk("R5 not taken", {31'd0, taken}, 32'd0);
  endtask

  task automatic testJal(); // R6, R8
    drive(32'h0000_3000, 32'hAAAA_AAAA, 32'h0, 32'hFFFF_F000, 2'b10, 3'b010);
    chk("R6 target", nextPc, 32'h0000_2000);
    chk("R6 taken", {31'd0, taken}, 32'd1);
    chk("R8 jal link", linkAddr, 32'h0000_3004);
  endtask

  task automatic testJalr(); // R7, R8
    drive(32'h0000_4000, 32'h0001_0001, 32'h0, 32'h0000_0004, 2'b11, 3'b000);
    chk("R7 odd clear", nextPc, 32'h0001_0004);
    chk("R7 taken", {31'd0, taken}, 32'd1);
    chk("R8 jalr link", linkAddr, 32'h0000_4004);
    drive(32'h0000_4000, 32'h0001_0000, 32'h0, 32'h0000_0003, 2'b11, 3'b000);
    chk("R7 sum odd", nextPc, 32'h0001_0002);
  endtask

  task automatic testWrap(); // R9
    drive(32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 2'b00, 3'b000);
    chk("R9 seq wrap", nextPc, 32'h0000_0000);
    drive(32'hFFFF_FFF0, 32'h0, 32'h0, 32'h0000_0020, 2'b10, 3'b000);
    chk("R9 jal wrap", nextPc, 32'h0000_0010);
    drive(32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0005, 2'b11, 3'b000);
    chk("R9 jalr wrap", nextPc, 32'h0000_0004);
  endtask

  task automatic testReservedCond(); // R10
    drive(32'h0000_5000, 32'h1, 32'h1, 32'h40, 2'b01, 3'b010);
    chk("R10 code2 taken", {31'd0, taken}, 32'd0);
    chk("R10 code2 next", nextPc, 32'h0000_5004);
    drive(32'h0000_5000, 32'h1, 32'h2, 32'h40, 2'b01, 3'b011);
    chk("R10 code3 next", nextPc, 32'h0000_5004);
  endtask

  initial begin
    pc = '0; src1 = '0; src2 = '0; imm = '0; instrClass = '0; brCond = '0;
    @(negedge clk);
    chk("R1 idle next", nextPc, 32'h4);
    testSequential();
    testEquality();
    testSigned();
    testUnsigned();
    testBranchBase();
    testJal();
    testJalr();
    testWrap();
    testReservedCond();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule